// File: doc/BRIEF.md
# Dual-Space Operand SRAM with Switchable Top Address Bit

This block is an 8,192-word by 24-bit static memory with its select, output and write control built in. Twelve low address bits go straight into the array. The thirteenth, most significant bit comes from a two-way selector. A mode input chooses whether that bit comes from an ordinary address input or from a bank-select input. This allows one array to be split at run time into two operand spaces. With the mode input tied to a high-order address line of the processor, operands of one kind fall in the upper half and operands of the other kind fall in the lower half, with no glue logic.

Two chip enables of opposite polarity must both be asserted for the block to be selected. When deselected the block reports standby and never drives its data bus. The bidirectional data bus appears as a separate input word, output word and drive-enable. A write takes place on a rising clock edge. Read data follows the current address combinationally. Storage is arranged as 512 rows of 384 bits, with 16 words in each row.

Top module: `dsp_part_sram`

## Requirements
- R1: The array holds 8,192 independent 24-bit words, addressed by a 13-bit effective address. Writing one address never alters another.
- R2: Effective address bits 11..0 equal `addr_lo`. Bit 12 equals `bank_xy` when `vs_sel` is 1 and `addr_hi` when `vs_sel` is 0. The same rule applies to reads and to writes.
- R3: When the block is selected (`ce1_n`=0 and `ce2`=1) and `we_n`=0, `dq_in` is stored at the effective address on the rising clock edge, whatever the value of `oe_n`. The new word can be read from the next cycle onward.
- R4: When `ce1_n`=1 or `ce2`=0, the block is deselected. `dq_oe` is 0, `standby` is 1, and no write takes place even if `we_n`=0.
- R5: When the block is selected with `we_n`=1 and `oe_n`=1, `dq_oe` is 0.
- R6: When the block is selected with `we_n`=1 and `oe_n`=0, `dq_oe` is 1 and `dq_out` shows the stored word at the effective address in the same cycle.
- R7: When the block is selected with `we_n`=0, `dq_oe` is 0, including when `oe_n`=0.
- R8: Whenever `dq_oe` is 0, `dq_out` is all zeros.
- R9: `standby` is 1 exactly when the block is deselected, and 0 when it is selected.
- R10: Row index = effective address bits 12..4 (512 rows). Word slot within a row = bits 3..0 (16 slots of 24 bits). A write changes only its own slot and leaves the other 15 words of the row intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| addr_lo | input | 12 | Low address bits 11..0 |
| addr_hi | input | 1 | Ordinary top address input |
| bank_xy | input | 1 | Bank-select top address input |
| vs_sel | input | 1 | 1: top bit from bank_xy, 0: from addr_hi |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | 24 | Write data |
| dq_out | output | 24 | Read data, zero when not driving |
| dq_oe | output | 1 | Data bus drive enable |
| standby | output | 1 | High while deselected |

## Verification
`dq_oe`, `standby` and `dq_out` are combinational functions of the inputs and the stored contents, so each result belongs to the cycle in which its inputs are applied. A write becomes visible only after the next rising edge. The bench applies each stimulus at a falling edge and records its expectation at that moment. The monitor compares the outputs 5 ns later, still before the following rising edge, so a read that comes after a write sees the committed data. The reference model updates after the expectation for the write cycle itself has been recorded.

// File: rtl/dsp_part_sram_pkg.sv
package dsp_part_sram_pkg;

  typedef enum logic [1:0] {
    ACC_OFF   = 2'd0,
    ACC_IDLE  = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_mode_e;

  function automatic logic chip_selected(input logic ce_lo_n, input logic ce_hi);
    return (!ce_lo_n) && ce_hi;
  endfunction

  function automatic acc_mode_e decode_mode(input logic sel, input logic wr_n,
                                            input logic rd_n);
    if (!sel)       return ACC_OFF;
    else if (!wr_n) return ACC_WRITE;
    else if (!rd_n) return ACC_READ;
    else            return ACC_IDLE;
  endfunction

endpackage

// File: rtl/dsp_part_sram_ctrl.sv
module dsp_part_sram_ctrl
  import dsp_part_sram_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2,
  input  logic      we_n,
  input  logic      oe_n,
  output acc_mode_e mode,
  output logic      wr_evt,
  output logic      rd_evt,
  output logic      standby
);

  logic sel;

  always_comb begin
    sel     = chip_selected(ce1_n, ce2);
    mode    = decode_mode(sel, we_n, oe_n);
    wr_evt  = (mode == ACC_WRITE);
    rd_evt  = (mode == ACC_READ);
    standby = (mode == ACC_OFF);
  end

endmodule

// File: rtl/dsp_part_sram_amux.sv
module dsp_part_sram_amux #(
  parameter int LO_AW    = 12,
  parameter int ROW_BITS = 9,
  localparam int AW       = LO_AW + 1,
  localparam int COL_BITS = AW - ROW_BITS
) (
  input  logic [LO_AW-1:0]    addr_lo,
  input  logic                addr_hi,
  input  logic                bank_xy,
  input  logic                vs_sel,
  output logic [AW-1:0]       eff_addr,
  output logic [ROW_BITS-1:0] row_idx,
  output logic [COL_BITS-1:0] col_idx
);

  function automatic logic [AW-1:0] join_addr(input logic [LO_AW-1:0] lo,
                                              input logic hi, input logic bx,
                                              input logic vs);
    logic top;
    top = vs ? bx : hi;
    return {top, lo};
  endfunction

  function automatic logic [ROW_BITS-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1 -: ROW_BITS];
  endfunction

  function automatic logic [COL_BITS-1:0] col_of(input logic [AW-1:0] a);
    return a[COL_BITS-1:0];
  endfunction

  always_comb begin
    eff_addr = join_addr(addr_lo, addr_hi, bank_xy, vs_sel);
    row_idx  = row_of(eff_addr);
    col_idx  = col_of(eff_addr);
  end

endmodule

// File: rtl/dsp_part_sram_array.sv
module dsp_part_sram_array #(
  parameter int DW       = 24,
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 4,
  localparam int ROWS  = 1 << ROW_BITS,
  localparam int COLS  = 1 << COL_BITS,
  localparam int ROW_W = DW * COLS
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] row_idx,
  input  logic [COL_BITS-1:0] col_idx,
  input  logic [DW-1:0]       wr_word,
  output logic [DW-1:0]       rd_word
);

  logic [ROW_W-1:0] rows [ROWS];
  logic [ROW_W-1:0] cur_row;
  logic [DW-1:0]    slot [COLS];

  always_ff @(posedge clk) begin
    for (int g = 0; g < COLS; g++) begin
      if (wr_en && (col_idx == COL_BITS'(g)))
        rows[row_idx][g*DW +: DW] <= wr_word;
    end
  end

  assign cur_row = rows[row_idx];

  for (genvar g = 0; g < COLS; g++) begin : g_slot
    assign slot[g] = cur_row[g*DW +: DW];
  end

  assign rd_word = slot[col_idx];

endmodule

// File: rtl/dsp_part_sram.sv
module dsp_part_sram
  import dsp_part_sram_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int LO_ADDR_W = 12,
  parameter int ROW_BITS  = 9,
  localparam int AW       = LO_ADDR_W + 1,
  localparam int COL_BITS = AW - ROW_BITS
) (
  input  logic                 clk,
  input  logic [LO_ADDR_W-1:0] addr_lo,
  input  logic                 addr_hi,
  input  logic                 bank_xy,
  input  logic                 vs_sel,
  input  logic                 ce1_n,
  input  logic                 ce2,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic [DATA_W-1:0]    dq_in,
  output logic [DATA_W-1:0]    dq_out,
  output logic                 dq_oe,
  output logic                 standby
);

  acc_mode_e           mode;
  logic                wr_evt;
  logic                rd_evt;
  logic [AW-1:0]       eff_addr;
  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [DATA_W-1:0]   rd_word;

  dsp_part_sram_ctrl u_ctrl (
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .mode    (mode),
    .wr_evt  (wr_evt),
    .rd_evt  (rd_evt),
    .standby (standby)
  );

  dsp_part_sram_amux #(
    .LO_AW    (LO_ADDR_W),
    .ROW_BITS (ROW_BITS)
  ) u_amux (
    .addr_lo  (addr_lo),
    .addr_hi  (addr_hi),
    .bank_xy  (bank_xy),
    .vs_sel   (vs_sel),
    .eff_addr (eff_addr),
    .row_idx  (row_idx),
    .col_idx  (col_idx)
  );

  dsp_part_sram_array #(
    .DW       (DATA_W),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_array (
    .clk     (clk),
    .wr_en   (wr_evt),
    .row_idx (row_idx),
    .col_idx (col_idx),
    .wr_word (dq_in),
    .rd_word (rd_word)
  );

  assign dq_oe  = rd_evt;
  assign dq_out = rd_evt ? rd_word : '0;

endmodule

// File: rtl/dsp_part_sram_chk.sv
module dsp_part_sram_chk #(
  parameter int DATA_W = 24,
  parameter int AW     = 13
) (
  input logic              clk,
  input logic              ce1_n,
  input logic              ce2,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_in,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              standby,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic [AW-1:0]     eff_addr
);

  logic chk_live = 1'b0;
  always_ff @(posedge clk) chk_live <= 1'b1;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!chk_live)
    (ce1_n || !ce2) |-> (!dq_oe && standby && !wr_evt)); // R4

  AST_OUTPUT_DISABLED: assert property (@(posedge clk) disable iff (!chk_live)
    (!ce1_n && ce2 && we_n && oe_n) |-> !dq_oe); // R5

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!chk_live)
    (!ce1_n && ce2 && we_n && !oe_n) |-> dq_oe); // R6

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!chk_live)
    (!ce1_n && ce2 && !we_n) |-> (!dq_oe && wr_evt)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!chk_live)
    !dq_oe |-> (dq_out == '0)); // R8

  AST_STANDBY_SELECT: assert property (@(posedge clk) disable iff (!chk_live)
    (!ce1_n && ce2) |-> !standby); // R9

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!chk_live)
    wr_evt ##1 (rd_evt && eff_addr == $past(eff_addr)) |-> dq_out == $past(dq_in)); // R3

endmodule

bind dsp_part_sram dsp_part_sram_chk #(
  .DATA_W (DATA_W),
  .AW     (AW)
) u_chk (
  .clk      (clk),
  .ce1_n    (ce1_n),
  .ce2      (ce2),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .dq_in    (dq_in),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .standby  (standby),
  .wr_evt   (wr_evt),
  .rd_evt   (rd_evt),
  .eff_addr (eff_addr)
);

// File: tb/dsp_part_sram_tb_top.sv
module dsp_part_sram_tb_top;

  typedef struct {
    logic        oe;
    logic [23:0] dout;
    logic        sb;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [11:0] addr_lo = '0;
  logic        addr_hi = 1'b0;
  logic        bank_xy = 1'b0;
  logic        vs_sel  = 1'b0;
  logic        ce1_n   = 1'b1;
  logic        ce2     = 1'b0;
  logic        we_n    = 1'b1;
  logic        oe_n    = 1'b1;
  logic [23:0] dq_in   = '0;
  logic [23:0] dq_out;
  logic        dq_oe;
  logic        standby;

  exp_t        exp_q[$];
  logic [23:0] model [int];
  int          n_checks = 0;
  int          n_fail   = 0;

  always #10 clk = ~clk;

  dsp_part_sram dut_i (
    .clk     (clk),
    .addr_lo (addr_lo),
    .addr_hi (addr_hi),
    .bank_xy (bank_xy),
    .vs_sel  (vs_sel),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dq_in   (dq_in),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .standby (standby)
  );

  task automatic drive(input logic c1n, input logic c2, input logic wn,
                       input logic on, input logic vs, input logic ah,
                       input logic bx, input logic [11:0] lo,
                       input logic [23:0] d, input string tag);
    exp_t e;
    logic sel;
    int   ea;
    @(negedge clk);
    ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on;
    vs_sel = vs; addr_hi = ah; bank_xy = bx; addr_lo = lo; dq_in = d;
    sel = !c1n && c2;
    ea  = {(vs ? bx : ah), lo};
    e.sb   = !sel;
    e.oe   = sel && wn && !on;
    e.dout = (e.oe && model.exists(ea)) ? model[ea] : 24'h0;
    e.tag  = tag;
    exp_q.push_back(e);
    if (sel && !wn) model[ea] = d;
  endtask

  task automatic wr(input logic vs, input logic ah, input logic bx,
                    input logic [11:0] lo, input logic [23:0] d, input string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b1, vs, ah, bx, lo, d, tag);
  endtask

  task automatic rd(input logic vs, input logic ah, input logic bx,
                    input logic [11:0] lo, input string tag);
    drive(1'b0, 1'b1, 1'b1, 1'b0, vs, ah, bx, lo, 24'h0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (dq_oe !== e.oe || dq_out !== e.dout || standby !== e.sb) begin
          n_fail++;
          $display("FAIL %s: got oe=%0b dout=%h sb=%0b, expected oe=%0b dout=%h sb=%0b",
                   e.tag, dq_oe, dq_out, standby, e.oe, e.dout, e.sb);
        end
      end
    end
  end

  task automatic run_all();
    // Idle, deselected state: R4 R8 R9
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 24'h0, "R4 idle deselect");
    // Write the two halves through addr_hi: R2 R3 R7
    wr(1'b0, 1'b1, 1'b0, 12'h123, 24'hAAAAAA, "R7 write upper via addr_hi");
    wr(1'b0, 1'b0, 1'b1, 12'h123, 24'h555555, "R7 write lower via addr_hi");
    // Read back selecting with bank_xy: R2 R6
    rd(1'b1, 1'b0, 1'b1, 12'h123, "R2 read upper via bank_xy");
    rd(1'b1, 1'b1, 1'b0, 12'h123, "R2 read lower via bank_xy");
    rd(1'b0, 1'b1, 1'b0, 12'h123, "R6 read upper via addr_hi");
    // Write through bank_xy with oe_n low during write: R3 R7
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h045, 24'h13579B, "R7 write oe_n low");
    rd(1'b0, 1'b1, 1'b0, 12'h045, "R3 read written via other path");
    rd(1'b0, 1'b0, 1'b1, 12'h123, "R2 lower half untouched");
    // Output disabled: R5
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h123, 24'h0, "R5 output disable");
    // Deselected writes are dropped: R4
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h123, 24'hFFFFFF, "R4 write ce2 low");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h123, 24'hEEEEEE, "R9 write ce1_n high");
    rd(1'b0, 1'b1, 1'b0, 12'h123, "R4 deselected write ignored");
    // Row slots: R10
    for (int c = 0; c < 16; c++)
      wr(1'b0, 1'b0, 1'b0, {8'hAB, 4'(c)}, 24'h0A0000 + 24'(c), "R10 row fill");
    wr(1'b0, 1'b0, 1'b0, 12'hAB5, 24'hDEAD55, "R10 slot overwrite");
    for (int c = 0; c < 16; c++)
      rd(1'b1, 1'b0, 1'b0, {8'hAB, 4'(c)}, "R10 row neighbours");
    // Address sweep across both halves: R1
    for (int i = 0; i < 32; i++)
      wr(1'b0, 1'(i), 1'b0, 12'((i * 127) % 4096), 24'(i * 24'h040B1D) ^ 24'h3C3C3C,
         "R1 sweep write");
    for (int i = 0; i < 32; i++)
      rd(1'b1, 1'b0, 1'(i), 12'((i * 127) % 4096), "R1 sweep read");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 24'h0, "R9 final deselect");
  endtask

  initial begin : main
    bit timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    @(negedge clk);
    #8;
    if (timed_out) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule